// File: doc/BRIEF.md
# Untranslated Access Range Protector

This block sets the permissions for memory accesses that bypass address translation. Read and execute are always allowed. Whether writes are allowed depends on up to `NUM_RANGES` programmable half-open address windows and two control bits. With protection disabled, every write is allowed. With protection enabled, the block ORs together the window hits. It then XORs that result with a polarity bit. The outcome says whether the address lies in the protected zone, where writes are refused and flagged as an access-rights fault, or in the writable zone.

Software programs the window bounds and control bits through a single-cycle write port. Accesses are decided combinationally from the effective address and a write flag. This lets the surrounding access pipeline register the result wherever it suits.

Top module: `bare_access_guard`

## Requirements
- R1: After reset all bound registers are zero, protection enable is 0 and polarity is 0, so every access (write included) is granted with no fault.
- R2: `perm_rd` and `perm_ex` are 1 for every access, whatever the configuration.
- R3: While protection enable is 0, `perm_wr` is 1 and `fault_valid` is 0 even for addresses inside an active window.
- R4: A window takes part only when its lower bound is strictly below its upper bound; a window with lower equal to or above upper never matches.
- R5: An address hits a window when lower <= address < upper: the lower bound is inside, the upper bound is outside.
- R6: The in-range term is the OR of the hits of all active windows.
- R7: With protection enabled and (in-range XOR polarity) = 1, a write gives `perm_wr` = 0, `fault_valid` = 1 and `fault_code` = 2 (access rights); `fault_code` is 0 whenever `fault_valid` is 0.
- R8: With protection enabled and (in-range XOR polarity) = 0, `perm_wr` is 1 and there is no fault; polarity 1 makes the outside of the windows the protected zone.
- R9: A read in the protected zone raises no fault and returns `perm_wr` = 0.
- R10: Register select codes: 0 and 1 are window 0 lower and upper, 2 and 3 window 1 lower and upper, 4 is control (bit 0 enable, bit 1 polarity); a write to any other select code changes nothing. A write takes effect from the next clock edge.
- R11: Bounds and addresses are compared as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| acc_addr | input | 32 | Effective address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read or fetch |
| perm_rd | output | 1 | Read permission |
| perm_ex | output | 1 | Execute permission |
| perm_wr | output | 1 | Write permission |
| fault_valid | output | 1 | Write refused in the protected zone |
| fault_code | output | 4 | Fault code, 2 for access rights, else 0 |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, two windows, and a 4-bit fault code. That makes a three-bit select space with three unused codes, so ignored writes can be tested. Full-width bounds near the top of the address space expose any signed comparison. Two windows are enough to test the union against disjoint windows and to test both degenerate-window forms, equal and inverted bounds.

// File: rtl/bag_pkg.sv
package bag_pkg;

   typedef struct packed {
      logic polarity;
      logic enable;
   } bag_ctrl_t;

   function automatic int unsigned bag_sel_width(input int unsigned nr);
      return $clog2(2 * nr + 1);
   endfunction

endpackage

// File: rtl/bag_cfg_regs.sv
module bag_cfg_regs
   import bag_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_RANGES = 2,
   localparam int unsigned SEL_W     = bag_sel_width(NUM_RANGES),
   localparam int unsigned CTRL_SEL  = 2 * NUM_RANGES
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [SEL_W-1:0]                 sel,
   input  logic [ADDR_W-1:0]                wdata,
   output logic [NUM_RANGES-1:0][ADDR_W-1:0] lo_q,
   output logic [NUM_RANGES-1:0][ADDR_W-1:0] hi_q,
   output bag_ctrl_t                        ctrl_q
);

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_bound
      localparam int unsigned LO_SEL = 2 * g;
      localparam int unsigned HI_SEL = 2 * g + 1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[g] <= '0;
         end else if (we && (sel == SEL_W'(LO_SEL))) begin
            lo_q[g] <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q[g] <= '0;
         end else if (we && (sel == SEL_W'(HI_SEL))) begin
            hi_q[g] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we && (sel == SEL_W'(CTRL_SEL))) begin
         ctrl_q.enable   <= wdata[0];
         ctrl_q.polarity <= wdata[1];
      end
   end

endmodule

// File: rtl/bag_window.sv
module bag_window #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] addr,
   output logic              active,
   output logic              hit
);

   logic above_lo;
   logic below_hi;

   always_comb begin
      active   = (lo < hi);
      above_lo = (addr >= lo);
      below_hi = (addr < hi);
      hit      = active && above_lo && below_hi;
   end

endmodule

// File: rtl/bag_decide.sv
module bag_decide #(
   parameter int unsigned           CODE_W      = 4,
   parameter logic [CODE_W-1:0]     RIGHTS_CODE = CODE_W'(2)
) (
   input  logic              in_range,
   input  logic              enable,
   input  logic              polarity,
   input  logic              is_write,
   output logic              wr_ok,
   output logic              fault,
   output logic [CODE_W-1:0] code
);

   logic protected_zone;

   always_comb begin
      protected_zone = enable && (in_range ^ polarity);
      wr_ok          = !protected_zone;
      fault          = protected_zone && is_write;
      code           = fault ? RIGHTS_CODE : '0;
   end

endmodule

// File: rtl/bare_access_guard.sv
module bare_access_guard
   import bag_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_RANGES = 2,
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned RIGHTS_VAL = 2,
   localparam int unsigned SEL_W     = bag_sel_width(NUM_RANGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              perm_rd,
   output logic              perm_ex,
   output logic              perm_wr,
   output logic              fault_valid,
   output logic [CODE_W-1:0] fault_code
);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
      $error("bare_access_guard: ADDR_W out of range");
   end
   if (NUM_RANGES < 1 || NUM_RANGES > 16) begin : g_bad_nr
      $error("bare_access_guard: NUM_RANGES out of range");
   end
   if (RIGHTS_VAL == 0 || RIGHTS_VAL >= (1 << CODE_W)) begin : g_bad_code
      $error("bare_access_guard: RIGHTS_VAL must be nonzero and fit CODE_W");
   end

   logic [NUM_RANGES-1:0][ADDR_W-1:0] lo_q;
   logic [NUM_RANGES-1:0][ADDR_W-1:0] hi_q;
   bag_ctrl_t                         ctrl_q;
   logic [NUM_RANGES-1:0]             win_active;
   logic [NUM_RANGES-1:0]             win_hit;
   logic                              any_hit;

   bag_cfg_regs #(
      .ADDR_W     (ADDR_W),
      .NUM_RANGES (NUM_RANGES)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .lo_q   (lo_q),
      .hi_q   (hi_q),
      .ctrl_q (ctrl_q)
   );

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
      bag_window #(
         .ADDR_W (ADDR_W)
      ) u_win (
         .lo     (lo_q[g]),
         .hi     (hi_q[g]),
         .addr   (acc_addr),
         .active (win_active[g]),
         .hit    (win_hit[g])
      );
   end

   assign any_hit = |win_hit;

   bag_decide #(
      .CODE_W      (CODE_W),
      .RIGHTS_CODE (CODE_W'(RIGHTS_VAL))
   ) u_decide (
      .in_range (any_hit),
      .enable   (ctrl_q.enable),
      .polarity (ctrl_q.polarity),
      .is_write (acc_write),
      .wr_ok    (perm_wr),
      .fault    (fault_valid),
      .code     (fault_code)
   );

   assign perm_rd = 1'b1;
   assign perm_ex = 1'b1;

endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned RIGHTS_VAL = 2,
   parameter int unsigned CTRL_SEL   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [SEL_W-1:0]  cfg_sel,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic              prot_en,
   input logic              prot_pol,
   input logic              acc_write,
   input logic              perm_rd,
   input logic              perm_ex,
   input logic              perm_wr,
   input logic              fault_valid,
   input logic [CODE_W-1:0] fault_code
);

   a_r2_rd_ex_granted: assert property (@(posedge clk) disable iff (!rst_n)
      perm_rd && perm_ex);

   a_r3_disabled_writes: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_en |-> (perm_wr && !fault_valid));

   a_r7_fault_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (acc_write && !perm_wr && fault_code == CODE_W'(RIGHTS_VAL)));

   a_r7_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid |-> (fault_code == '0));

   a_r8_granted_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      perm_wr |-> !fault_valid);

   a_r9_read_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_write |-> !fault_valid);

   a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(CTRL_SEL)) |=>
         (prot_en == $past(cfg_wdata[0]) && prot_pol == $past(cfg_wdata[1])));

   a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == SEL_W'(CTRL_SEL)) |=> ($stable(prot_en) && $stable(prot_pol)));

endmodule

bind bare_access_guard bag_checker #(
   .ADDR_W     (ADDR_W),
   .SEL_W      (SEL_W),
   .CODE_W     (CODE_W),
   .RIGHTS_VAL (RIGHTS_VAL),
   .CTRL_SEL   (2 * NUM_RANGES)
) u_bag_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_sel     (cfg_sel),
   .cfg_wdata   (cfg_wdata),
   .prot_en     (ctrl_q.enable),
   .prot_pol    (ctrl_q.polarity),
   .acc_write   (acc_write),
   .perm_rd     (perm_rd),
   .perm_ex     (perm_ex),
   .perm_wr     (perm_wr),
   .fault_valid (fault_valid),
   .fault_code  (fault_code)
);

// File: tb/bare_access_guard_test.sv
module bare_access_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        perm_rd, perm_ex, perm_wr, fault_valid;
   logic [3:0]  fault_code;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bare_access_guard uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_wdata   (cfg_wdata),
      .acc_addr    (acc_addr),
      .acc_write   (acc_write),
      .perm_rd     (perm_rd),
      .perm_ex     (perm_ex),
      .perm_wr     (perm_wr),
      .fault_valid (fault_valid),
      .fault_code  (fault_code)
   );

   task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // Expected write grant and fault; fault code is 2 when faulting, else 0.
   task automatic probe(input logic [31:0] addr, input logic wr,
                        input logic exp_wr, input logic exp_flt, input string req);
      logic [3:0] exp_code;
      @(negedge clk);
      acc_addr  = addr;
      acc_write = wr;
      #1;
      exp_code = exp_flt ? 4'd2 : 4'd0;
      checks++;
      if (perm_rd !== 1'b1 || perm_ex !== 1'b1 || perm_wr !== exp_wr ||
          fault_valid !== exp_flt || fault_code !== exp_code) begin
         errors++;
         $display("FAIL %s addr=%h wr=%0b: rd/ex/wr/flt/code=%b%b%b%b/%0d expected 11%b%b/%0d",
                  req, addr, wr, perm_rd, perm_ex, perm_wr, fault_valid, fault_code,
                  exp_wr, exp_flt, exp_code);
      end
   endtask

   task automatic t_reset;
      probe(32'h0000_1000, 1'b1, 1'b1, 1'b0, "R1");
      probe(32'h0000_0000, 1'b0, 1'b1, 1'b0, "R1");
   endtask

   task automatic t_disabled;
      wr_reg(3'd0, 32'h100);
      wr_reg(3'd1, 32'h200);
      probe(32'h150, 1'b1, 1'b1, 1'b0, "R3");
   endtask

   task automatic t_basic;
      wr_reg(3'd4, 32'h1);
      probe(32'h100, 1'b1, 1'b0, 1'b1, "R5_R7");
      probe(32'h1FF, 1'b1, 1'b0, 1'b1, "R5_R7");
      probe(32'h200, 1'b1, 1'b1, 1'b0, "R5_R8");
      probe(32'h0FF, 1'b1, 1'b1, 1'b0, "R5_R8");
      probe(32'h150, 1'b0, 1'b0, 1'b0, "R9");
      probe(32'h150, 1'b1, 1'b0, 1'b1, "R2_R7");
   endtask

   task automatic t_inactive;
      wr_reg(3'd0, 32'h300);
      wr_reg(3'd1, 32'h300);
      probe(32'h300, 1'b1, 1'b1, 1'b0, "R4");
      wr_reg(3'd0, 32'h500);
      wr_reg(3'd1, 32'h400);
      probe(32'h450, 1'b1, 1'b1, 1'b0, "R4");
      probe(32'h500, 1'b1, 1'b1, 1'b0, "R4");
   endtask

   task automatic t_union;
      wr_reg(3'd0, 32'h100);
      wr_reg(3'd1, 32'h200);
      wr_reg(3'd2, 32'h1000);
      wr_reg(3'd3, 32'h2000);
      probe(32'h1800, 1'b1, 1'b0, 1'b1, "R6");
      probe(32'h180,  1'b1, 1'b0, 1'b1, "R6");
      probe(32'h800,  1'b1, 1'b1, 1'b0, "R6");
   endtask

   task automatic t_polarity;
      wr_reg(3'd4, 32'h3);
      probe(32'h800,  1'b1, 1'b0, 1'b1, "R8");
      probe(32'h150,  1'b1, 1'b1, 1'b0, "R8");
      probe(32'h1800, 1'b1, 1'b1, 1'b0, "R8");
      probe(32'h800,  1'b0, 1'b0, 1'b0, "R9");
   endtask

   task automatic t_unsigned;
      wr_reg(3'd4, 32'h1);
      wr_reg(3'd2, 32'h0);
      wr_reg(3'd3, 32'h0);
      wr_reg(3'd0, 32'h10);
      wr_reg(3'd1, 32'hFFFF_FFF0);
      probe(32'h8000_0000, 1'b1, 1'b0, 1'b1, "R11");
      probe(32'hFFFF_FFF0, 1'b1, 1'b1, 1'b0, "R11");
      probe(32'h0000_000F, 1'b1, 1'b1, 1'b0, "R11");
   endtask

   task automatic t_regmap;
      for (int s = 5; s < 8; s++) wr_reg(3'(s), 32'h0);
      probe(32'h8000_0000, 1'b1, 1'b0, 1'b1, "R10");
      wr_reg(3'd4, 32'h0);
      probe(32'h8000_0000, 1'b1, 1'b1, 1'b0, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_disabled();
      t_basic();
      t_inactive();
      t_union();
      t_polarity();
      t_unsigned();
      t_regmap();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule